// File: doc/BRIEF.md
# Privileged Status Word Modifier

This block holds a 16-bit processor status word and applies immediate logical operations to it. The low byte is the condition-code byte. A modify strobe selects AND, OR or exclusive-OR with a 16-bit immediate. A size select chooses the target. A byte-size operation reaches only the condition-code byte and is always allowed. A word-size operation reaches the whole word and is allowed only while the supervisor bit is set.

A word-size attempt made outside supervisor mode leaves the word as it was and raises a one-cycle privilege-fault pulse. When no modify strobe is present, an execution unit can load the five condition flags through a separate flag strobe. Bits with no function always read as zero. The reset input is asynchronous and active low. It is released synchronously inside the block.

Top module: `statreg_modifier`

## Requirements
- R1: While reset is asserted, and after it is released, `sr_q` reads 0x2700 and `priv_fault` reads 0. The reset state has supervisor set, mask 7, trace clear and all flags clear.
- R2: Bit positions are fixed as follows: trace at bit 15, supervisor at bit 13, interrupt mask at bits 10:8, and the flags X, N, Z, V, C at bits 4, 3, 2, 1, 0. Bits 14, 12, 11 and 7:5 always read 0, whatever value is written to them.
- R3: `mod_op` encodes 00 as AND, 01 as OR and 10 as exclusive-OR. The result is taken with the immediate and appears on `sr_q` in the cycle after the strobe.
- R4: With `mod_word`=0 the operation uses `mod_imm[7:0]` on bits 7:0 only, and bits 15:8 stay unchanged. This is allowed in both modes. A byte AND with 0x00 clears all five flags.
- R5: With `mod_word`=1 and supervisor=1 the operation uses all 16 immediate bits on the whole word. An OR with 0x8000 sets the trace bit.
- R6: With `mod_word`=1 and supervisor=0 the word is unchanged, and `priv_fault` is 1 for exactly the next cycle per attempt. This applies to any `mod_op` value.
- R7: The privilege check uses the supervisor bit as it was before the write. A legal word write may clear supervisor, and any later word write then faults.
- R8: `mod_op`=11 is reserved. It leaves the word unchanged and raises no fault unless R6 applies.
- R9: With `mod_en`=0 and `flg_en`=1, bits 4:0 load `flg_in` in the next cycle and all other bits are unchanged.
- R10: `mod_en` has priority over `flg_en`. `flg_in` is ignored in any cycle that has a modify strobe.
- R11: With neither strobe active, the word holds its value and `priv_fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Modify strobe |
| mod_op | input | 2 | Operation: 00 AND, 01 OR, 10 XOR, 11 reserved |
| mod_word | input | 1 | 1 = whole word, 0 = condition-code byte |
| mod_imm | input | 16 | Immediate operand |
| flg_en | input | 1 | Flag-load strobe from the execution unit |
| flg_in | input | 5 | New X,N,Z,V,C values (bit 4 = X) |
| sr_q | output | 16 | Current status word |
| priv_fault | output | 1 | One-cycle privilege-violation pulse |

## Verification
The word is visible on the ports in every cycle. A wrong next-state shows up one cycle after the strobe that caused it. A wrong target mask shows as upper bits that change on a byte operation, or as unused bits that read 1. A wrong privilege decision shows in the same cycle in two ways: a changed word together with a missing fault, or a fault where none should be. A stale or mis-sampled supervisor bit only shows on the first word write after supervisor is cleared. For that reason the vector walk clears supervisor with a legal write and then attempts another word write straight away.

// File: rtl/statreg_pkg.sv
package statreg_pkg;

  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_XOR  = 2'b10,
    OP_RSVD = 2'b11
  } sr_op_e;

  localparam int unsigned DEF_SR_W   = 16;
  localparam int unsigned DEF_CCR_W  = 8;
  localparam int unsigned DEF_FLAG_W = 5;
  localparam int unsigned DEF_S_POS  = 13;
  localparam logic [15:0] DEF_IMPL   = 16'hA71F;
  localparam logic [15:0] DEF_RST    = 16'h2700;

endpackage

// File: rtl/statreg_rst_sync.sv
module statreg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/statreg_logic_op.sv
module statreg_logic_op
  import statreg_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  sr_op_e       op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         op_valid
);

  for (genvar i = 0; i < W; i++) begin : g_lane
    always_comb begin
      unique case (op)
        OP_AND:  y[i] = a[i] & b[i];
        OP_OR:   y[i] = a[i] | b[i];
        OP_XOR:  y[i] = a[i] ^ b[i];
        default: y[i] = a[i];
      endcase
    end
  end

  assign op_valid = (op != OP_RSVD);

endmodule

// File: rtl/statreg_priv_gate.sv
module statreg_priv_gate (
  input  logic mod_en,
  input  logic mod_word,
  input  logic op_valid,
  input  logic super_bit,
  output logic word_wr,
  output logic byte_wr,
  output logic fault_nxt
);

  always_comb begin
    word_wr   = 1'b0;
    byte_wr   = 1'b0;
    fault_nxt = 1'b0;
    if (mod_en) begin
      if (mod_word) begin
        if (super_bit) begin
          word_wr = op_valid;
        end else begin
          fault_nxt = 1'b1;
        end
      end else begin
        byte_wr = op_valid;
      end
    end
  end

endmodule

// File: rtl/statreg_modifier.sv
module statreg_modifier
  import statreg_pkg::*;
#(
  parameter int unsigned SR_W   = DEF_SR_W,
  parameter int unsigned CCR_W  = DEF_CCR_W,
  parameter int unsigned FLAG_W = DEF_FLAG_W,
  parameter int unsigned S_POS  = DEF_S_POS,
  parameter logic [SR_W-1:0] IMPL_MASK = DEF_IMPL,
  parameter logic [SR_W-1:0] RST_VAL   = DEF_RST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic [1:0]        mod_op,
  input  logic              mod_word,
  input  logic [SR_W-1:0]   mod_imm,
  input  logic              flg_en,
  input  logic [FLAG_W-1:0] flg_in,
  output logic [SR_W-1:0]   sr_q,
  output logic              priv_fault
);

  localparam int unsigned HI_W = SR_W - CCR_W;
  localparam int unsigned FX_W = SR_W - FLAG_W;
  localparam logic [SR_W-1:0] RST_MASKED = RST_VAL & IMPL_MASK;

  logic              rst_core_n;
  sr_op_e            op_sel;
  logic [SR_W-1:0]   word_res;
  logic [CCR_W-1:0]  byte_res;
  logic              word_valid;
  logic              byte_valid;
  logic              word_wr;
  logic              byte_wr;
  logic              fault_nxt;
  logic [SR_W-1:0]   sr_r;
  logic [SR_W-1:0]   sr_nxt;
  logic              sr_ce;
  logic              fault_r;

  statreg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  assign op_sel = sr_op_e'(mod_op);

  statreg_logic_op #(.W(SR_W)) u_word_op (
    .op       (op_sel),
    .a        (sr_r),
    .b        (mod_imm),
    .y        (word_res),
    .op_valid (word_valid)
  );

  statreg_logic_op #(.W(CCR_W)) u_byte_op (
    .op       (op_sel),
    .a        (sr_r[CCR_W-1:0]),
    .b        (mod_imm[CCR_W-1:0]),
    .y        (byte_res),
    .op_valid (byte_valid)
  );

  statreg_priv_gate u_priv (
    .mod_en    (mod_en),
    .mod_word  (mod_word),
    .op_valid  (word_valid & byte_valid),
    .super_bit (sr_r[S_POS]),
    .word_wr   (word_wr),
    .byte_wr   (byte_wr),
    .fault_nxt (fault_nxt)
  );

  // Next-state: modify strobe first, flag load only when no modify strobe.
  always_comb begin
    logic [SR_W-1:0] raw;
    raw   = sr_r;
    sr_ce = 1'b0;
    if (word_wr) begin
      raw   = word_res;
      sr_ce = 1'b1;
    end else if (byte_wr) begin
      raw   = {sr_r[SR_W-1 -: HI_W], byte_res};
      sr_ce = 1'b1;
    end else if (!mod_en && flg_en) begin
      raw   = {sr_r[SR_W-1 -: FX_W], flg_in};
      sr_ce = 1'b1;
    end
    sr_nxt = raw & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sr_r <= RST_MASKED;
    end else if (sr_ce) begin
      sr_r <= sr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      fault_r <= 1'b0;
    end else begin
      fault_r <= fault_nxt;
    end
  end

  assign sr_q       = sr_r;
  assign priv_fault = fault_r;

endmodule

// File: rtl/statreg_checker.sv
module statreg_checker #(
  parameter int unsigned SR_W   = 16,
  parameter int unsigned CCR_W  = 8,
  parameter int unsigned FLAG_W = 5,
  parameter int unsigned S_POS  = 13,
  parameter logic [SR_W-1:0] IMPL_MASK = 16'hA71F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mod_en,
  input logic              mod_word,
  input logic              flg_en,
  input logic [FLAG_W-1:0] flg_in,
  input logic [SR_W-1:0]   sr_q,
  input logic              priv_fault
);

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q & ~IMPL_MASK) == '0);

  assert_byte_keeps_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !mod_word) |=> (sr_q[SR_W-1:CCR_W] == $past(sr_q[SR_W-1:CCR_W])));

  assert_user_word_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && mod_word && !sr_q[S_POS]) |=> ($stable(sr_q) && priv_fault));

  assert_fault_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |-> $past(mod_en && mod_word && !sr_q[S_POS]));

  assert_flag_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_en && flg_en) |=> (sr_q[FLAG_W-1:0] == $past(flg_in)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_en && !flg_en) |=> ($stable(sr_q) && !priv_fault));

endmodule

bind statreg_modifier statreg_checker #(
  .SR_W(SR_W), .CCR_W(CCR_W), .FLAG_W(FLAG_W), .S_POS(S_POS), .IMPL_MASK(IMPL_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .mod_en     (mod_en),
  .mod_word   (mod_word),
  .flg_en     (flg_en),
  .flg_in     (flg_in),
  .sr_q       (sr_q),
  .priv_fault (priv_fault)
);

// File: tb/statreg_modifier_bench.sv
module statreg_modifier_bench;

  logic        clk;
  logic        rst_n;
  logic        mod_en;
  logic [1:0]  mod_op;
  logic        mod_word;
  logic [15:0] mod_imm;
  logic        flg_en;
  logic [4:0]  flg_in;
  logic [15:0] sr_q;
  logic        priv_fault;

  int n_run;
  int n_fail;

  statreg_modifier u_statreg_modifier (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .mod_op(mod_op),
    .mod_word(mod_word), .mod_imm(mod_imm), .flg_en(flg_en), .flg_in(flg_in),
    .sr_q(sr_q), .priv_fault(priv_fault)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {en, op[1:0], word, imm[15:0], fen, flg[4:0], exp_sr[15:0], exp_fault}
  localparam int NV = 17;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 2'b01, 1'b0, 16'h00FF, 1'b0, 5'h00, 16'h271F, 1'b0}, // R4 R2 byte OR
    {1'b1, 2'b00, 1'b0, 16'hFF00, 1'b0, 5'h00, 16'h2700, 1'b0}, // R4 byte AND 0 clears flags
    {1'b1, 2'b10, 1'b0, 16'h0015, 1'b0, 5'h00, 16'h2715, 1'b0}, // R3 byte XOR
    {1'b1, 2'b01, 1'b1, 16'h8000, 1'b0, 5'h00, 16'hA715, 1'b0}, // R5 trace on
    {1'b1, 2'b00, 1'b1, 16'hFFFF, 1'b0, 5'h00, 16'hA715, 1'b0}, // R3 word AND
    {1'b1, 2'b10, 1'b1, 16'h0300, 1'b0, 5'h00, 16'hA415, 1'b0}, // R5 word XOR mask
    {1'b1, 2'b01, 1'b1, 16'h58E0, 1'b0, 5'h00, 16'hA415, 1'b0}, // R2 unused bits
    {1'b1, 2'b11, 1'b1, 16'h0000, 1'b0, 5'h00, 16'hA415, 1'b0}, // R8 reserved
    {1'b0, 2'b00, 1'b0, 16'h0000, 1'b1, 5'h0A, 16'hA40A, 1'b0}, // R9 flag load
    {1'b1, 2'b01, 1'b0, 16'h0001, 1'b1, 5'h1F, 16'hA40B, 1'b0}, // R10 priority
    {1'b0, 2'b00, 1'b0, 16'hFFFF, 1'b0, 5'h1F, 16'hA40B, 1'b0}, // R11 idle
    {1'b1, 2'b00, 1'b1, 16'h5FFF, 1'b0, 5'h00, 16'h040B, 1'b0}, // R7 clear S legally
    {1'b1, 2'b01, 1'b1, 16'h2000, 1'b0, 5'h00, 16'h040B, 1'b1}, // R6 R7 user word
    {1'b0, 2'b00, 1'b0, 16'h0000, 1'b0, 5'h00, 16'h040B, 1'b0}, // R6 one cycle
    {1'b1, 2'b10, 1'b0, 16'h00FF, 1'b0, 5'h00, 16'h0414, 1'b0}, // R4 byte in user
    {1'b1, 2'b11, 1'b1, 16'h0000, 1'b0, 5'h00, 16'h0414, 1'b1}, // R8 R6 reserved user
    {1'b0, 2'b00, 1'b0, 16'h0000, 1'b1, 5'h1F, 16'h041F, 1'b0}  // R9 flag load
  };

  task automatic check(input string tag, input logic [15:0] exp_sr, input logic exp_f);
    n_run++;
    if (sr_q !== exp_sr || priv_fault !== exp_f) begin
      n_fail++;
      $display("FAIL %s: sr=%h fault=%b expected sr=%h fault=%b",
               tag, sr_q, priv_fault, exp_sr, exp_f);
    end
  endtask

  task automatic drive(input logic en, input logic [1:0] op, input logic wd,
                       input logic [15:0] imm, input logic fen, input logic [4:0] fl);
    mod_en = en; mod_op = op; mod_word = wd; mod_imm = imm; flg_en = fen; flg_in = fl;
    @(posedge clk);
    @(negedge clk);
    mod_en = 1'b0; flg_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async", 16'h2700, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 release", 16'h2700, 1'b0);
  endtask

  initial begin
    #800000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run=%0d expected completion", n_run);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0;
    mod_en = 1'b0; mod_op = 2'b00; mod_word = 1'b0; mod_imm = '0;
    flg_en = 1'b0; flg_in = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 16'h2700, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 16'h2700, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      v = VEC[i];
      drive(v[42], v[41:40], v[39], v[38:23], v[22], v[21:17]);
      check($sformatf("vector %0d (R2-R11)", i), v[16:1], v[0]);
    end

    // R6: back-to-back user word attempts fault on each cycle
    mod_en = 1'b1; mod_op = 2'b01; mod_word = 1'b1; mod_imm = 16'hFFFF;
    @(posedge clk); @(negedge clk);
    check("R6 first attempt", 16'h041F, 1'b1);
    @(posedge clk); @(negedge clk);
    mod_en = 1'b0;
    check("R6 second attempt", 16'h041F, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R6 fault drops", 16'h041F, 1'b0);

    // R1: async reset mid-run from user mode
    do_reset();

    // R5 R7: after reset supervisor is back, word OR 0x8000 sets trace
    drive(1'b1, 2'b01, 1'b1, 16'h8000, 1'b0, 5'h00);
    check("R5 trace after reset", 16'hA700, 1'b0);

    // R4: byte AND 0x00 clears all flags after full flag load
    drive(1'b0, 2'b00, 1'b0, 16'h0000, 1'b1, 5'h1F);
    check("R9 flags set", 16'hA71F, 1'b0);
    drive(1'b1, 2'b00, 1'b0, 16'h0000, 1'b0, 5'h00);
    check("R4 clear flags", 16'hA700, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule